// File: doc/BRIEF.md
# Chained-Operation Integer Execution Unit

This unit executes one 32-bit integer instruction per cycle. Each instruction computes `A op (B op C)`. In the first stage an inner operation combines registers B and C. In the second stage an outer operation combines register A with that partial result, and the outcome is written back to a destination register. When the outer operation is a comparison, the instruction produces a condition flag instead of a register write. Every result, register-writing or not, leaves the unit on a result stream so that a consumer can observe it.

Instructions arrive on a valid/ready stream and results leave on a second valid/ready stream. A transfer happens on a rising edge where valid and ready are both high. The result stream may be held off at any time: while `res_valid` is high and `res_ready` is low, every result field holds steady. The stall then spreads back through the second stage to `ins_ready` and blocks new instructions. Nothing is dropped or duplicated. `ins_ready` is high whenever the result slot is empty. A result appears on `res_valid` in the second cycle after its instruction is accepted.

The hazard rule works differently for the two operand paths. The inner operands B and C are read from the register file in the cycle the instruction is accepted. They do not see the write of the instruction that is in stage one at that moment. The outer operand A receives the result of the instruction directly ahead by forwarding.

Top module: `chained_op_unit`

## Requirements
- R1: After reset `res_valid` is low, `ins_ready` is high, and register k holds the value k for every k.
- R2: The instruction fields are: bits 31:28 outer opcode, 27:24 inner opcode, 23:19 destination, 18:14 A, 13:9 B, 8:4 C, and 3:0 ignored. The result is outer(A, inner(B, C)).
- R3: The opcodes are 0 add, 1 subtract (left minus right), 2 and, 3 or, 4 xor, 5 shift-left (left shifted by the low 5 bits of right), 6 low 32 bits of the product, and 7 pass (yields the right operand). Codes 10 to 15 behave as pass.
- R4: Opcode 8 is signed less-than (left < right) and opcode 9 is equality. As the outer op, a compare sets `res_is_flag`=1, puts the truth in `res_flag` and as 0/1 in `res_data`, and writes no register. As the inner op, a compare yields the value 0 or 1. For non-compare results `res_flag` is 0.
- R5: With `res_ready` held high, one instruction is accepted every cycle. Results leave in issue order, each carrying its destination index in `res_dest`.
- R6: The inner operands of an instruction accepted in the cycle right after its predecessor see the register value from before the predecessor's write. An instruction accepted one cycle later sees the new value.
- R7: The outer A operand receives the result of the instruction immediately ahead, even when that instruction is accepted in the previous cycle.
- R8: Register 0 always reads as zero, and a write aimed at it is discarded. Its result is not forwarded either.
- R9: While `res_valid` is high and `res_ready` is low, the result fields stay stable. `ins_ready` falls once both stages are occupied. After release, every result is delivered exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction word present |
| ins_ready | output | 1 | Unit can accept an instruction this cycle |
| ins_word | input | 32 | Instruction word |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer accepts the result |
| res_dest | output | 5 | Destination index of the result |
| res_data | output | 32 | Outer-stage result value |
| res_is_flag | output | 1 | Result came from a compare |
| res_flag | output | 1 | Compare outcome |

## Verification
Back-pressure and the hazard rule can act in the same cycle. The held result slot is also the forwarding source for the A operand, and the instruction behind it reads its stale inner operands on the same edge on which the held instruction writes back. The bench provokes this with a writer followed directly by a reader of the same register on both the A and the C path, issued while `res_ready` is low. It judges the case by the single combined result, which must be the stale C value plus the forwarded A value. It also checks the held output during the stall and the order of the results after release.

// File: rtl/cop_pkg.sv
package cop_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SHL  = 4'd5,
    OP_MUL  = 4'd6,
    OP_PASS = 4'd7,
    OP_SLT  = 4'd8,
    OP_SEQ  = 4'd9
  } op_e;

  typedef struct packed {
    logic [3:0]        outer;
    logic [3:0]        inner;
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic [RIDX_W-1:0] rc;
    logic [3:0]        spare;
  } ins_t;

  function automatic logic op_is_cmp(input logic [3:0] op);
    return (op == OP_SLT) || (op == OP_SEQ);
  endfunction
endpackage

// File: rtl/cop_alu.sv
module cop_alu
  import cop_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res
);
  localparam int SH_W = $clog2(W);
  logic [2*W-1:0] prod;

  always_comb begin
    prod = lhs * rhs;
    case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_AND:  res = lhs & rhs;
      OP_OR:   res = lhs | rhs;
      OP_XOR:  res = lhs ^ rhs;
      OP_SHL:  res = lhs << rhs[SH_W-1:0];
      OP_MUL:  res = prod[W-1:0];
      OP_SLT:  res = {{(W-1){1'b0}}, ($signed(lhs) < $signed(rhs))};
      OP_SEQ:  res = {{(W-1){1'b0}}, (lhs == rhs)};
      default: res = rhs;
    endcase
  end
endmodule

// File: rtl/cop_regfile.sv
module cop_regfile
  import cop_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NREG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [$clog2(N)-1:0] ra_addr,
  output logic [W-1:0]         ra_data,
  input  logic [$clog2(N)-1:0] rb_addr,
  output logic [W-1:0]         rb_data,
  input  logic [$clog2(N)-1:0] rc_addr,
  output logic [W-1:0]         rc_data,
  input  logic                 wr_en,
  input  logic [$clog2(N)-1:0] wr_addr,
  input  logic [W-1:0]         wr_data
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) mem[k] <= W'(k);
    end else if (wr_en && wr_addr != '0) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign ra_data = (ra_addr == '0) ? '0 : mem[ra_addr];
  assign rb_data = (rb_addr == '0) ? '0 : mem[rb_addr];
  assign rc_data = (rc_addr == '0) ? '0 : mem[rc_addr];
endmodule

// File: rtl/chained_op_unit.sv
module chained_op_unit
  import cop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [XLEN-1:0]   ins_word,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [RIDX_W-1:0] res_dest,
  output logic [XLEN-1:0]   res_data,
  output logic              res_is_flag,
  output logic              res_flag
);
  ins_t ins;
  assign ins = ins_t'(ins_word);

  // register file reads happen in the acceptance cycle
  logic [XLEN-1:0]   rd_a_data, rd_b_data, rd_c_data;
  logic [RIDX_W-1:0] rd_b_addr;
  logic              wr_en;
  logic [RIDX_W-1:0] wr_addr;
  logic [XLEN-1:0]   wr_data;
  assign rd_b_addr = ins.rb;

  cop_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_addr(ins.ra), .ra_data(rd_a_data),
    .rb_addr(rd_b_addr), .rb_data(rd_b_data),
    .rc_addr(ins.rc), .rc_data(rd_c_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // stage one: inner operation
  logic [XLEN-1:0] inner_res;
  cop_alu #(.W(XLEN)) u_inner (
    .op(ins.inner), .lhs(rd_b_data), .rhs(rd_c_data), .res(inner_res)
  );

  logic              s1_v;
  logic [3:0]        s1_op;
  logic [RIDX_W-1:0] s1_dst, s1_ra;
  logic [XLEN-1:0]   s1_aval, s1_inner;

  // result slot
  logic              o_v, o_we, o_flagged, o_flag;
  logic [RIDX_W-1:0] o_dst;
  logic [XLEN-1:0]   o_data;

  logic advance, move, fire_in, s1_cmp;
  assign advance   = !o_v || res_ready;
  assign move      = s1_v && advance;
  assign ins_ready = !s1_v || advance;
  assign fire_in   = ins_valid && ins_ready;
  assign s1_cmp    = op_is_cmp(s1_op);

  // stage two: outer operation with A forwarded from the result slot
  logic [XLEN-1:0] a_fwd, outer_res;
  assign a_fwd = (o_v && o_we && o_dst == s1_ra) ? o_data : s1_aval;

  cop_alu #(.W(XLEN)) u_outer (
    .op(s1_op), .lhs(a_fwd), .rhs(s1_inner), .res(outer_res)
  );

  assign wr_en   = move && !s1_cmp && (s1_dst != '0);
  assign wr_addr = s1_dst;
  assign wr_data = outer_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_op    <= '0;
      s1_dst   <= '0;
      s1_ra    <= '0;
      s1_aval  <= '0;
      s1_inner <= '0;
    end else if (ins_ready) begin
      s1_v <= fire_in;
      if (fire_in) begin
        s1_op    <= ins.outer;
        s1_dst   <= ins.dst;
        s1_ra    <= ins.ra;
        s1_aval  <= rd_a_data;
        s1_inner <= inner_res;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_v       <= 1'b0;
      o_we      <= 1'b0;
      o_flagged <= 1'b0;
      o_flag    <= 1'b0;
      o_dst     <= '0;
      o_data    <= '0;
    end else if (advance) begin
      o_v <= s1_v;
      if (s1_v) begin
        o_we      <= wr_en;
        o_flagged <= s1_cmp;
        o_flag    <= s1_cmp && outer_res[0];
        o_dst     <= s1_dst;
        o_data    <= outer_res;
      end
    end
  end

  assign res_valid   = o_v;
  assign res_dest    = o_dst;
  assign res_data    = o_data;
  assign res_is_flag = o_flagged;
  assign res_flag    = o_flag;
endmodule

// File: rtl/chained_op_unit_chk.sv
module chained_op_unit_chk
  import cop_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ins_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [RIDX_W-1:0] res_dest,
  input logic [XLEN-1:0]   res_data,
  input logic              res_is_flag,
  input logic              res_flag,
  input logic [RIDX_W-1:0] rd_b_addr,
  input logic [XLEN-1:0]   rd_b_data,
  input logic              wr_en,
  input logic [RIDX_W-1:0] wr_addr,
  input logic              move,
  input logic              s1_cmp
);
  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_dest)
      && $stable(res_is_flag) && $stable(res_flag));

  a_r9_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ins_ready);

  a_r8_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_addr == '0 |-> rd_b_data == '0);

  a_r8_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr != '0);

  a_r4_compare_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    move && s1_cmp |-> !wr_en);

  a_r4_flag_only_compare: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_is_flag |-> !res_flag);
endmodule

bind chained_op_unit chained_op_unit_chk u_chk (.*);

// File: tb/tb_chained_op_unit.sv
module tb_chained_op_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [31:0] ins_word = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [4:0]  res_dest;
  logic [31:0] res_data;
  logic        res_is_flag, res_flag;

  always #2 clk = ~clk;

  chained_op_unit dut (.*);

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] cap_data [64];
  logic [4:0]  cap_dest [64];
  logic        cap_isf  [64];
  logic        cap_flag [64];
  int          cap_n = 0;

  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready && cap_n < 64) begin
      cap_data[cap_n] = res_data;
      cap_dest[cap_n] = res_dest;
      cap_isf[cap_n]  = res_is_flag;
      cap_flag[cap_n] = res_flag;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int o, input int i, input int d,
                                     input int a, input int b, input int c);
    return {o[3:0], i[3:0], d[4:0], a[4:0], b[4:0], c[4:0], 4'hA};
  endfunction

  localparam int ADD = 0, SUB = 1, PAS = 7, SLT = 8, SEQ = 9;

  // caller is aligned 1ns after a rising edge; returns aligned
  task automatic issue(input logic [31:0] w);
    ins_valid = 1'b1;
    ins_word  = w;
    @(negedge clk);
    while (!ins_ready) @(negedge clk);
    @(posedge clk);
    #1;
    ins_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain(input int want);
    int guard = 0;
    while (cap_n < want && guard < 100) begin
      @(posedge clk);
      guard++;
    end
    #1;
    chk(cap_n == want, "R9", "result count", cap_n, want);
  endtask

  task automatic expect_at(input int k, input string req, input logic [31:0] exp);
    chk(cap_data[k] == exp, req, $sformatf("result %0d", k), cap_data[k], exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
    chk(ins_ready == 1'b1, "R1", "ins_ready after reset", ins_ready, 1);
    @(posedge clk); #1;
    cap_n = 0;
    issue(mk(PAS, PAS, 0, 0, 0, 5));
    issue(mk(PAS, PAS, 0, 0, 0, 31));
    drain(2);
    expect_at(0, "R1", 5);
    expect_at(1, "R1", 31);
  endtask

  task automatic t_ops;
    logic [31:0] exp [9];
    exp = '{32'd13, 32'hFFFF_FFFF, 32'd6, 32'd7, 32'd1, 32'd768, 32'd42, 32'd7, 32'd7};
    cap_n = 0;
    for (int op = 0; op < 8; op++) issue(mk(op, PAS, 0, 6, 0, 7));
    issue(mk(12, PAS, 0, 6, 0, 7));
    drain(9);
    for (int k = 0; k < 9; k++) expect_at(k, "R3", exp[k]);
    // back-to-back: nine results, first capture order equals issue order
    chk(cap_dest[8] == 5'd0, "R5", "dest field of last", cap_dest[8], 0);
    cap_n = 0;
    issue(mk(ADD, SUB, 10, 3, 9, 4));
    idle(2);
    issue(mk(PAS, PAS, 0, 0, 0, 10));
    drain(2);
    expect_at(0, "R2", 8);
    chk(cap_dest[0] == 5'd10, "R5", "res_dest", cap_dest[0], 10);
    expect_at(1, "R2", 8);
  endtask

  task automatic t_cmp;
    cap_n = 0;
    issue(mk(SLT, PAS, 2, 2, 0, 3));
    issue(mk(ADD, PAS, 0, 2, 0, 0));
    issue(mk(SLT, SUB, 0, 2, 0, 1));
    issue(mk(SEQ, PAS, 0, 4, 0, 4));
    issue(mk(PAS, SEQ, 0, 0, 1, 1));
    idle(2);
    issue(mk(PAS, PAS, 0, 0, 0, 2));
    drain(6);
    chk(cap_isf[0] && cap_flag[0], "R4", "less-than flag", {cap_isf[0], cap_flag[0]}, 3);
    expect_at(0, "R4", 1);
    expect_at(1, "R4", 2);
    chk(cap_isf[2] && !cap_flag[2], "R4", "signed less-than", {cap_isf[2], cap_flag[2]}, 2);
    chk(cap_isf[3] && cap_flag[3], "R4", "equal flag", {cap_isf[3], cap_flag[3]}, 3);
    chk(!cap_isf[4] && cap_data[4] == 1, "R4", "inner compare value", cap_data[4], 1);
    expect_at(5, "R4", 2);
  endtask

  task automatic t_hazard;
    cap_n = 0;
    issue(mk(PAS, PAS, 12, 0, 0, 20));
    issue(mk(PAS, PAS, 0, 0, 0, 12));
    issue(mk(PAS, PAS, 0, 0, 0, 12));
    drain(3);
    expect_at(1, "R6", 12);
    expect_at(2, "R6", 20);
    cap_n = 0;
    issue(mk(PAS, PAS, 13, 0, 0, 21));
    issue(mk(ADD, PAS, 0, 13, 0, 0));
    drain(2);
    expect_at(1, "R7", 21);
  endtask

  task automatic t_zero;
    cap_n = 0;
    issue(mk(PAS, PAS, 0, 0, 0, 9));
    issue(mk(ADD, PAS, 0, 0, 0, 1));
    idle(2);
    issue(mk(ADD, ADD, 0, 0, 0, 0));
    drain(3);
    expect_at(0, "R8", 9);
    expect_at(1, "R8", 1);
    expect_at(2, "R8", 0);
  endtask

  task automatic t_stall;
    cap_n = 0;
    res_ready = 1'b0;
    fork
      begin
        issue(mk(PAS, PAS, 14, 0, 0, 22));
        issue(mk(ADD, PAS, 0, 14, 0, 14));
        issue(mk(PAS, PAS, 0, 0, 0, 14));
      end
      begin
        idle(8);
        @(negedge clk);
        chk(res_valid == 1'b1, "R9", "valid held", res_valid, 1);
        chk(res_data == 32'd22, "R9", "data held", res_data, 22);
        chk(ins_ready == 1'b0, "R9", "ins_ready low when full", ins_ready, 0);
        chk(cap_n == 0, "R9", "no transfer while stalled", cap_n, 0);
        res_ready = 1'b1;
      end
    join
    drain(3);
    expect_at(0, "R9", 22);
    expect_at(1, "R7", 36);
    expect_at(2, "R6", 22);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ops();
    t_cmp();
    t_hazard();
    t_zero();
    t_stall();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule